// File: doc/BRIEF.md
# Repeating-Value Sequence Counter

This block is a synchronous counter whose 3-bit output walks through one of three fixed, non-binary sequences. In two of the sequences the same output value shows up more than once per period and is followed by different values each time. The output alone therefore cannot hold the count. A hidden 3-bit position register carries it instead, and a combinational decoder maps the position to the output value for the selected sequence.

The sequence is picked by a 2-bit selector that is sampled only while the synchronous reset is active. Between resets the selector has no effect. When the enable input is high the counter moves forward by exactly one entry on each rising clock edge. When it is low the counter holds. The counter never skips an entry and never counts backwards.

Top module: `seq_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the counter goes to position 0 of the sequence chosen by `sel`. The value shown is then 1 for selector code 0, 0 for code 1, and 0 for code 2.
- R2: With selector code 0 captured, successive enabled edges produce the values 1, 4, 2, 3, after which the sequence returns to 1.
- R3: With selector code 1 captured, the values are 0, 0, 1, 1, 2, 2, 3, 3, after which the sequence returns to 0. Each value is shown for two consecutive steps.
- R4: With selector code 2 captured, the values are 0, 1, 0, 2, 0, 3, after which the sequence repeats. The value 0 is followed in turn by 1, 2 and 3.
- R5: At a rising edge with `en` low and `rst` low, the position and the output value stay unchanged.
- R6: At a rising edge with `en` high and `rst` low, the counter advances exactly one entry. It never advances more than one.
- R7: Selector code 3 behaves exactly like selector code 0.
- R8: While `rst` is low, changes on `sel` have no effect. The captured sequence changes only at the next reset.
- R9: The internal position is never an unused code for the captured sequence. Any unused code returns to position 0 on the next clock, so long runs keep following the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; also captures `sel` |
| en | input | 1 | Advance enable; low holds the counter |
| sel | input | 2 | Sequence selector (0, 1, 2; 3 aliases 0) |
| value | output | 3 | Current sequence value |

## Verification
Each sequence is walked for more than two full periods with `en` held high. This shows that the wrap point is right and that a repeated value is followed by the correct successor each time. Runs with `en` toggled in irregular patterns show that holding never loses or adds a step. Changing `sel` in the middle of a run, and then resetting, tells the capture-at-reset behaviour apart from live selection. Resetting with code 3 tells the alias apart from the other two sequences.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  localparam int VAL_W = 3;
  localparam int POS_W = 3;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_QUAD  = 2'd0,
    SEL_PAIR  = 2'd1,
    SEL_HUB   = 2'd2,
    SEL_ALIAS = 2'd3
  } sel_e;

  // Fold the spare selector code onto the first sequence.
  function automatic sel_e norm_sel(input logic [SEL_W-1:0] raw);
    sel_e s;
    s = sel_e'(raw);
    if (s == SEL_ALIAS) s = SEL_QUAD;
    return s;
  endfunction

  // Last legal position of each sequence.
  function automatic logic [POS_W-1:0] last_pos(input sel_e s);
    logic [POS_W-1:0] l;
    case (s)
      SEL_PAIR: l = 3'd7;
      SEL_HUB:  l = 3'd5;
      default:  l = 3'd3;
    endcase
    return l;
  endfunction

  // Output value for a position of a sequence.
  function automatic logic [VAL_W-1:0] entry(input sel_e s, input logic [POS_W-1:0] p);
    logic [VAL_W-1:0] v;
    case (s)
      SEL_PAIR: v = {1'b0, p[2:1]};
      SEL_HUB:  v = p[0] ? ({1'b0, p[2:1]} + 3'd1) : 3'd0;
      default: begin
        case (p[1:0])
          2'd0:    v = 3'd1;
          2'd1:    v = 3'd4;
          2'd2:    v = 3'd2;
          default: v = 3'd3;
        endcase
      end
    endcase
    return v;
  endfunction
endpackage

// File: rtl/seqc_sel_latch.sv
module seqc_sel_latch
  import seqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_raw,
  output sel_e             sel_q
);
  always_ff @(posedge clk) begin
    if (rst) sel_q <= norm_sel(sel_raw);
  end
endmodule

// File: rtl/seqc_stepper.sv
module seqc_stepper
  import seqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  sel_e             sel_q,
  output logic [POS_W-1:0] pos,
  output logic             at_last,
  output logic             legal
);
  logic [POS_W-1:0] lim;
  logic [POS_W-1:0] pos_nxt;

  always_comb begin
    lim     = last_pos(sel_q);
    legal   = (pos <= lim);
    at_last = (pos == lim);
    if (!legal)       pos_nxt = '0;
    else if (!en)     pos_nxt = pos;
    else if (at_last) pos_nxt = '0;
    else              pos_nxt = pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= pos_nxt;
  end
endmodule

// File: rtl/seqc_decode.sv
module seqc_decode
  import seqc_pkg::*;
(
  input  sel_e             sel_q,
  input  logic [POS_W-1:0] pos,
  output logic [VAL_W-1:0] value
);
  always_comb value = entry(sel_q, pos);
endmodule

// File: rtl/seq_counter.sv
module seq_counter
  import seqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [VAL_W-1:0] value
);
  sel_e             sel_w;
  logic [POS_W-1:0] pos_w;
  logic             wrap_w;
  logic             legal_w;

  seqc_sel_latch u_latch (.clk(clk), .rst(rst), .sel_raw(sel), .sel_q(sel_w));

  seqc_stepper u_step (
    .clk(clk), .rst(rst), .en(en), .sel_q(sel_w),
    .pos(pos_w), .at_last(wrap_w), .legal(legal_w)
  );

  seqc_decode u_dec (.sel_q(sel_w), .pos(pos_w), .value(value));
endmodule

// File: rtl/seqc_chk.sv
module seqc_chk
  import seqc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en,
  input sel_e             sel,
  input logic [POS_W-1:0] pos,
  input logic             wrap,
  input logic             legal
);
  AST_RESET_FIRST: assert property (@(posedge clk) rst |=> pos == '0); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && legal) |=> $stable(pos)); // R5
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && legal && !wrap) |=> pos == $past(pos) + 3'd1); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && wrap) |=> pos == '0); // R2
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(sel)); // R8
  AST_NO_ALIAS_SEL: assert property (@(posedge clk) disable iff (rst)
    sel != SEL_ALIAS); // R7
  AST_POS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    legal); // R9
endmodule

bind seq_counter seqc_chk i_chk (
  .clk(clk), .rst(rst), .en(en), .sel(sel_w),
  .pos(pos_w), .wrap(wrap_w), .legal(legal_w)
);

// File: tb/test_seq_counter.sv
`timescale 1ns/1ps
module test_seq_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [2:0] value;

  int n_chk  = 0;
  int n_fail = 0;
  int idx    = 0;
  int cur    = 0;

  always #2.5 clk = ~clk;

  seq_counter i_seq_counter (.clk(clk), .rst(rst), .en(en), .sel(sel), .value(value));

  function automatic int plen(input int m);
    if (m == 1) return 8;
    if (m == 2) return 6;
    return 4;
  endfunction

  function automatic int pval(input int m, input int k);
    int a0[4] = '{1, 4, 2, 3};
    int a1[8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    int a2[6] = '{0, 1, 0, 2, 0, 3};
    if (m == 1) return a1[k % 8];
    if (m == 2) return a2[k % 6];
    return a0[k % 4];
  endfunction

  task automatic check(input int exp, input string tag);
    n_chk++;
    if (int'(value) != exp) begin
      n_fail++;
      $display("FAIL %s: value=%0d expected=%0d (step %0d)", tag, value, exp, idx);
    end
  endtask

  task automatic do_reset(input int m, input string tag);
    @(negedge clk);
    rst = 1'b1; en = 1'b0; sel = 2'(m);
    @(negedge clk);
    rst = 1'b0;
    cur = (m == 3) ? 0 : m;
    idx = 0;
    check(pval(cur, 0), tag);
  endtask

  // One step: set en, wait past the edge, then check the new value.
  task automatic step(input logic e, input string tag);
    en = e;
    @(negedge clk);
    if (e) idx = (idx + 1) % plen(cur);
    check(pval(cur, idx), tag);
  endtask

  task automatic t_reset_values;
    do_reset(0, "R1");
    do_reset(1, "R1");
    do_reset(2, "R1");
  endtask

  task automatic t_walk(input int m, input string tag);
    do_reset(m, tag);
    for (int k = 0; k < 2 * plen(m) + 3; k++) step(1'b1, tag);
  endtask

  task automatic t_hold;
    do_reset(1, "R5");
    for (int k = 0; k < 3; k++) step(1'b1, "R6");
    for (int k = 0; k < 4; k++) step(1'b0, "R5");
    for (int k = 0; k < 6; k++) step(1'b1, "R6");
  endtask

  task automatic t_alias;
    do_reset(3, "R7");
    for (int k = 0; k < 9; k++) step(1'b1, "R7");
  endtask

  task automatic t_sel_ignored;
    do_reset(2, "R8");
    for (int k = 0; k < 10; k++) begin
      sel = 2'(k % 4);
      step(1'b1, "R8");
    end
    do_reset(1, "R8");
    step(1'b1, "R8");
    step(1'b1, "R8");
  endtask

  task automatic t_long;
    do_reset(2, "R9");
    for (int k = 0; k < 120; k++) step(((k * 7) % 5) != 2, "R9");
    do_reset(0, "R9");
    for (int k = 0; k < 60; k++) step((k % 3) != 0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_values();
    t_walk(0, "R2");
    t_walk(1, "R3");
    t_walk(2, "R4");
    t_hold();
    t_alias();
    t_sel_ignored();
    t_long();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: value=%0d expected=finished", value);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule